// File: doc/BRIEF.md
# Transmit Gather Engine

This block assembles outgoing frames from one or more host fragments. Software posts a 64-bit descriptor that names a host address, a byte count and two flags. The engine first waits until the transmit buffer has room for the fragment together with the bytes already gathered. It then issues one DMA read request for the fragment and waits for the completion strobe. When the completion arrives, the fragment length is added to the frame that is being assembled.

A fragment that carries the more flag leaves the frame open. A fragment without that flag closes the frame. The engine then pushes the whole frame into the transmit buffer, together with the checksum-request flag of the closing descriptor. A per-descriptor done word reports whether the engine is busy, whether it has finished, whether an error occurred and how many bytes were copied.

The engine keeps its own byte count of buffer occupancy. A push adds to this count, and a frame leaving on the wire side subtracts from it. All interrupt causes come out as one-cycle pulses. The causes are fragment copied, buffer nearly full, frame sent, occupancy below the low mark, frame too long, and a descriptor posted while busy.

Top module: `tx_gather_engine`

## Requirements
- R1: The descriptor layout is: bit 63 is the more flag, bit 62 is the checksum request, bits 61:46 are the length and bits 45:0 are the address. A post made while the engine is not busy is accepted. On the next cycle the done word reads 0x8000_0000 (bit 31 is busy).
- R2: A post made while busy is ignored: the stored descriptor keeps its address and length. Interrupt bit 5 pulses for one cycle.
- R3: The engine does not request DMA while the buffer free space is smaller than the gathered bytes plus the descriptor length. It waits until frames leave the buffer.
- R4: `dma_req` is high for exactly one cycle per fragment, with `dma_addr` and `dma_len` taken from the descriptor.
- R5: On the cycle after `dma_done`, the done word is bit 30 (complete) ORed with the fragment length, and busy is cleared.
- R6: A fragment with the more flag set pushes no frame, adds its length to the open frame, and pulses interrupt bit 0.
- R7: A fragment without the more flag pushes one frame. The push carries the total gathered length and that descriptor's checksum flag. Interrupt bit 0 pulses in the same cycle as the push.
- R8: After a push, if the buffer size minus the occupancy is below the max-copy threshold, interrupt bit 1 pulses together with the push.
- R9: A post accepted in the cycle after a completion returns the engine to the wait state directly, so `dma_req` rises two cycles after that post. Without such a post the engine goes idle.
- R10: A frame leaving the buffer (`frame_pop` with its length) pulses interrupt bit 2 on the next cycle. Bit 3 pulses with it if the occupancy after removal is below the low mark.
- R11: If the gathered bytes plus the descriptor length exceed the maximum frame size, no DMA is issued. The done word becomes 0x6000_0000 (complete and error, bit 29), interrupt bit 4 pulses, and the open frame is discarded.
- R12: During reset the done word, `dma_req`, `frame_push` and all interrupt bits are zero.
- R13: The occupancy never exceeds the buffer size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_valid | input | 1 | Descriptor post strobe |
| post_desc | input | 64 | Descriptor: more, checksum, length, address |
| done_word | output | 32 | Busy, complete, error flags and copied length |
| dma_req | output | 1 | One-cycle DMA read request |
| dma_addr | output | 46 | Host address of the fragment |
| dma_len | output | 16 | Fragment length in bytes |
| dma_done | input | 1 | DMA read completion strobe |
| frame_push | output | 1 | Frame pushed into the transmit buffer |
| frame_len | output | 16 | Length of the pushed frame |
| frame_csum | output | 1 | Checksum request for the pushed frame |
| frame_pop | input | 1 | A frame left the buffer toward the wire |
| pop_len | input | 16 | Length of the departing frame |
| intr | output | 6 | Interrupt pulses: 0 fragment, 1 full, 2 sent, 3 low, 4 oversize, 5 post error |

## Verification
The bench targets the following corner cases:
- A descriptor that does not fit. A design that compared only free space against the length, ignoring gathered bytes, would issue DMA early and overflow the buffer.
- A post landing in the cycle right after a completion. A design that always passed through idle would delay the next request by a cycle.
- An oversize chain. A design that kept the stale open length would push a wrong frame length afterwards.
- The full and low thresholds. These are checked exactly at their boundaries against the bench's own occupancy model, so an off-by-one comparison fires the wrong interrupt bit.

// File: rtl/txg_pkg.sv
package txg_pkg;

    localparam int DESC_W = 64;
    localparam int FLEN_W = 16;
    localparam int ADDR_W = DESC_W - 2 - FLEN_W;
    localparam int DONE_W = 32;

    localparam int IRQ_FRAG   = 0;
    localparam int IRQ_FULL   = 1;
    localparam int IRQ_SENT   = 2;
    localparam int IRQ_LOW    = 3;
    localparam int IRQ_OVSIZE = 4;
    localparam int IRQ_POSTER = 5;
    localparam int IRQ_W      = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_ROOM,
        ST_ISSUE,
        ST_XFER,
        ST_FINISH
    } txg_state_e;

    typedef struct packed {
        logic              more;
        logic              csum;
        logic [FLEN_W-1:0] len;
        logic [ADDR_W-1:0] addr;
    } txg_desc_t;

    typedef struct packed {
        logic              fire;
        logic [FLEN_W-1:0] len;
        logic              csum;
    } txg_push_t;

    function automatic logic [DONE_W-1:0] make_done(
        input logic busy, input logic cmpl, input logic err,
        input logic [FLEN_W-1:0] len);
        return {busy, cmpl, err, {(DONE_W-3-FLEN_W){1'b0}}, len};
    endfunction

endpackage

// File: rtl/txg_occupancy.sv
module txg_occupancy
    import txg_pkg::*;
#(
    parameter int BUF_BYTES = 32768,
    parameter int LOW_MARK  = 8192,
    parameter int MAX_COPY  = 2048,
    parameter int CNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_fire,
    input  logic [FLEN_W-1:0] push_len,
    input  logic              pop_fire,
    input  logic [FLEN_W-1:0] pop_len,
    output logic [CNT_W-1:0]  free,
    output logic              full_evt,
    output logic              low_evt
);

    logic [CNT_W-1:0] used_q;
    logic [31:0]      sum_add;
    logic [31:0]      sub_amt;
    logic [31:0]      used_nx;

    always_comb begin
        sum_add = 32'(used_q) + (push_fire ? 32'(push_len) : 32'd0);
        sub_amt = pop_fire ? 32'(pop_len) : 32'd0;
        used_nx = (sub_amt > sum_add) ? 32'd0 : sum_add - sub_amt;
    end

    always_ff @(posedge clk) begin
        if (rst) used_q <= '0;
        else     used_q <= CNT_W'(used_nx);
    end

    assign free     = CNT_W'(32'(BUF_BYTES) - 32'(used_q));
    assign full_evt = push_fire && ((32'(BUF_BYTES) - used_nx) < 32'(MAX_COPY));
    assign low_evt  = pop_fire && (used_nx < 32'(LOW_MARK));

    assert_no_overflow_R13: assert property (@(posedge clk) disable iff (rst)
        32'(used_q) <= 32'(BUF_BYTES));

endmodule

// File: rtl/txg_fsm.sv
module txg_fsm
    import txg_pkg::*;
#(
    parameter int MAX_FRAME = 16384,
    parameter int CNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              post_valid,
    input  logic [DESC_W-1:0] post_desc,
    input  logic              dma_done,
    input  logic [CNT_W-1:0]  free,
    output logic [DONE_W-1:0] done_word,
    output logic              dma_req,
    output logic [ADDR_W-1:0] dma_addr,
    output logic [FLEN_W-1:0] dma_len,
    output txg_push_t         push,
    output logic              frag_evt,
    output logic              ovsize_evt,
    output logic              poster_evt
);

    txg_state_e        state_q, state_d;
    txg_desc_t         desc_q;
    logic              busy_q;
    logic [DONE_W-1:0] done_q;
    logic [FLEN_W-1:0] asm_q;
    logic              post_ok;
    logic [31:0]       need;
    logic              too_big;
    logic              short_room;

    assign post_ok    = post_valid && !busy_q;
    assign need       = 32'(asm_q) + 32'(desc_q.len);
    assign too_big    = need > 32'(MAX_FRAME);
    assign short_room = 32'(free) < need;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (post_ok) state_d = ST_WAIT_ROOM;
            ST_WAIT_ROOM: begin
                if (too_big)          state_d = ST_IDLE;
                else if (!short_room) state_d = ST_ISSUE;
            end
            ST_ISSUE:     state_d = ST_XFER;
            ST_XFER:      if (dma_done) state_d = ST_FINISH;
            ST_FINISH:    state_d = post_ok ? ST_WAIT_ROOM : ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            desc_q  <= '0;
            busy_q  <= 1'b0;
            done_q  <= '0;
            asm_q   <= '0;
        end else begin
            state_q <= state_d;
            if (post_ok) begin
                desc_q <= txg_desc_t'(post_desc);
                busy_q <= 1'b1;
                done_q <= make_done(1'b1, 1'b0, 1'b0, '0);
            end
            if (state_q == ST_WAIT_ROOM && too_big) begin
                busy_q <= 1'b0;
                done_q <= make_done(1'b0, 1'b1, 1'b1, '0);
                asm_q  <= '0;
            end
            if (state_q == ST_XFER && dma_done) begin
                busy_q <= 1'b0;
                done_q <= make_done(1'b0, 1'b1, 1'b0, desc_q.len);
                asm_q  <= asm_q + desc_q.len;
            end
            if (state_q == ST_FINISH && !desc_q.more) asm_q <= '0;
        end
    end

    assign done_word  = done_q;
    assign dma_req    = (state_q == ST_ISSUE);
    assign dma_addr   = desc_q.addr;
    assign dma_len    = desc_q.len;
    assign push.fire  = (state_q == ST_FINISH) && !desc_q.more;
    assign push.len   = asm_q;
    assign push.csum  = desc_q.csum;
    assign frag_evt   = (state_q == ST_FINISH);
    assign ovsize_evt = (state_q == ST_WAIT_ROOM) && too_big;
    assign poster_evt = post_valid && busy_q;

    assert_post_sets_busy_R1: assert property (@(posedge clk) disable iff (rst)
        post_ok |=> (busy_q && done_q[DONE_W-1]));
    assert_issue_has_room_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ISSUE) |-> (32'(free) >= 32'(asm_q) + 32'(desc_q.len)));
    assert_copy_clears_busy_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_XFER && dma_done) |=> (!busy_q && done_q[DONE_W-2]));
    assert_push_bounded_R11: assert property (@(posedge clk) disable iff (rst)
        push.fire |-> (32'(push.len) <= 32'(MAX_FRAME)));

endmodule

// File: rtl/txg_evt_reg.sv
module txg_evt_reg
    import txg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  txg_push_t         push,
    input  logic [IRQ_W-1:0]  evt,
    output logic              frame_push,
    output logic [FLEN_W-1:0] frame_len,
    output logic              frame_csum,
    output logic [IRQ_W-1:0]  intr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_push <= 1'b0;
            frame_len  <= '0;
            frame_csum <= 1'b0;
            intr       <= '0;
        end else begin
            frame_push <= push.fire;
            frame_len  <= push.fire ? push.len : '0;
            frame_csum <= push.fire && push.csum;
            intr       <= evt;
        end
    end

endmodule

// File: rtl/tx_gather_engine.sv
module tx_gather_engine
    import txg_pkg::*;
#(
    parameter int BUF_BYTES = 32768,
    parameter int LOW_MARK  = 8192,
    parameter int MAX_COPY  = 2048,
    parameter int MAX_FRAME = 16384
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              post_valid,
    input  logic [63:0]       post_desc,
    output logic [31:0]       done_word,
    output logic              dma_req,
    output logic [45:0]       dma_addr,
    output logic [15:0]       dma_len,
    input  logic              dma_done,
    output logic              frame_push,
    output logic [15:0]       frame_len,
    output logic              frame_csum,
    input  logic              frame_pop,
    input  logic [15:0]       pop_len,
    output logic [5:0]        intr
);

    localparam int CNT_W = $clog2(BUF_BYTES + 1);

    logic [CNT_W-1:0] free;
    txg_push_t        push;
    logic             full_evt, low_evt, frag_evt, ovsize_evt, poster_evt;
    logic [IRQ_W-1:0] evt;

    txg_fsm #(.MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W)) fsm_i (
        .clk        (clk),
        .rst        (rst),
        .post_valid (post_valid),
        .post_desc  (post_desc),
        .dma_done   (dma_done),
        .free       (free),
        .done_word  (done_word),
        .dma_req    (dma_req),
        .dma_addr   (dma_addr),
        .dma_len    (dma_len),
        .push       (push),
        .frag_evt   (frag_evt),
        .ovsize_evt (ovsize_evt),
        .poster_evt (poster_evt)
    );

    txg_occupancy #(
        .BUF_BYTES (BUF_BYTES),
        .LOW_MARK  (LOW_MARK),
        .MAX_COPY  (MAX_COPY),
        .CNT_W     (CNT_W)
    ) occ_i (
        .clk       (clk),
        .rst       (rst),
        .push_fire (push.fire),
        .push_len  (push.len),
        .pop_fire  (frame_pop),
        .pop_len   (pop_len),
        .free      (free),
        .full_evt  (full_evt),
        .low_evt   (low_evt)
    );

    always_comb begin
        evt             = '0;
        evt[IRQ_FRAG]   = frag_evt;
        evt[IRQ_FULL]   = full_evt;
        evt[IRQ_SENT]   = frame_pop;
        evt[IRQ_LOW]    = low_evt;
        evt[IRQ_OVSIZE] = ovsize_evt;
        evt[IRQ_POSTER] = poster_evt;
    end

    txg_evt_reg evt_i (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .evt        (evt),
        .frame_push (frame_push),
        .frame_len  (frame_len),
        .frame_csum (frame_csum),
        .intr       (intr)
    );

    assert_push_with_frag_irq_R7: assert property (@(posedge clk) disable iff (rst)
        frame_push |-> intr[IRQ_FRAG]);

endmodule

// File: tb/tx_gather_engine_tb_top.sv
module tx_gather_engine_tb_top;

    localparam int BUF  = 4096;
    localparam int LOWM = 1024;
    localparam int MCPY = 1024;
    localparam int MFRM = 3000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        post_valid = 1'b0;
    logic [63:0] post_desc = '0;
    logic [31:0] done_word;
    logic        dma_req;
    logic [45:0] dma_addr;
    logic [15:0] dma_len;
    logic        dma_done = 1'b0;
    logic        frame_push;
    logic [15:0] frame_len;
    logic        frame_csum;
    logic        frame_pop = 1'b0;
    logic [15:0] pop_len = '0;
    logic [5:0]  intr;

    int n_checks = 0;
    int n_err = 0;
    int used_m = 0;
    int asm_m = 0;
    int q[$];
    bit finished = 0;

    always #10 clk = ~clk;

    tx_gather_engine #(.BUF_BYTES(BUF), .LOW_MARK(LOWM), .MAX_COPY(MCPY),
                       .MAX_FRAME(MFRM)) dut_i (
        .clk(clk), .rst(rst), .post_valid(post_valid), .post_desc(post_desc),
        .done_word(done_word), .dma_req(dma_req), .dma_addr(dma_addr),
        .dma_len(dma_len), .dma_done(dma_done), .frame_push(frame_push),
        .frame_len(frame_len), .frame_csum(frame_csum), .frame_pop(frame_pop),
        .pop_len(pop_len), .intr(intr)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_desc(input bit more, input bit csum,
                                            input int len, input logic [45:0] a);
        return {more, csum, 16'(len), a};
    endfunction

    function automatic logic [31:0] done_cmpl(input int len);
        return 32'h4000_0000 | 32'(len);
    endfunction

    task automatic post_frag(input logic [45:0] a, input int len, input bit more, input bit csum);
        post_valid = 1'b1;
        post_desc  = mk_desc(more, csum, len, a);
        step();
        post_valid = 1'b0;
        chk("R1 done word busy after post", 64'(done_word), 64'h8000_0000);
    endtask

    task automatic finish_frag(input logic [45:0] a, input int len, input bit more,
                               input bit csum, input bit chain, input logic [63:0] nxt);
        bit seen = 0;
        logic [5:0] exp_i;
        bit full;
        for (int k = 0; k < 60; k++) begin
            if (dma_req) begin seen = 1; break; end
            step();
        end
        chk("R4 dma request seen", 64'(seen), 64'd1);
        chk("R4 dma address", 64'(dma_addr), 64'(a));
        chk("R4 dma length", 64'(dma_len), 64'(len));
        step();
        chk("R4 request lasts one cycle", 64'(dma_req), 64'd0);
        repeat ($urandom_range(0, 3)) step();
        dma_done = 1'b1;
        step();
        dma_done = 1'b0;
        chk("R5 done word after completion", 64'(done_word), 64'(done_cmpl(len)));
        asm_m += len;
        if (chain) begin
            post_valid = 1'b1;
            post_desc  = nxt;
        end
        step();
        post_valid = 1'b0;
        exp_i = 6'b000001;
        full = 0;
        if (!more) begin
            used_m += asm_m;
            full = (BUF - used_m) < MCPY;
            if (full) exp_i[1] = 1'b1;
        end
        chk("R6 R7 R8 interrupt pulses after fragment", 64'(intr), 64'(exp_i));
        chk("R6 R7 frame push strobe", 64'(frame_push), 64'(!more));
        if (!more) begin
            chk("R7 pushed frame length", 64'(frame_len), 64'(asm_m));
            chk("R7 pushed checksum flag", 64'(frame_csum), 64'(csum));
            q.push_back(asm_m);
            asm_m = 0;
        end
        if (chain) begin
            chk("R9 chained post accepted", 64'(done_word), 64'h8000_0000);
            chk("R9 no request yet", 64'(dma_req), 64'd0);
            step();
            chk("R9 request two cycles after chained post", 64'(dma_req), 64'd1);
        end
    endtask

    task automatic do_pop();
        int pl;
        logic [5:0] exp_i;
        pl = q.pop_front();
        frame_pop = 1'b1;
        pop_len   = 16'(pl);
        step();
        frame_pop = 1'b0;
        pop_len   = '0;
        used_m -= pl;
        exp_i = 6'b000100;
        if (used_m < LOWM) exp_i[3] = 1'b1;
        chk("R10 sent and low interrupts", 64'(intr), 64'(exp_i));
    endtask

    task automatic drain();
        while (q.size() > 0) do_pop();
    endtask

    task automatic run_frag(input logic [45:0] a, input int len, input bit more, input bit csum);
        post_frag(a, len, more, csum);
        finish_frag(a, len, more, csum, 1'b0, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        repeat (3) step();
        chk("R12 reset done word", 64'(done_word), 64'd0);
        chk("R12 reset dma_req", 64'(dma_req), 64'd0);
        chk("R12 reset frame_push", 64'(frame_push), 64'd0);
        chk("R12 reset intr", 64'(intr), 64'd0);
        rst = 1'b0;
        step();

        // single fragment frame with checksum
        run_frag(46'h12_3456_7800, 300, 1'b0, 1'b1);
        drain();

        // R2: second post while busy
        post_frag(46'h00_0000_1000, 200, 1'b0, 1'b0);
        post_valid = 1'b1;
        post_desc  = mk_desc(1'b1, 1'b1, 77, 46'h3F_FFFF_0000);
        step();
        post_valid = 1'b0;
        chk("R2 post-while-busy interrupt", 64'(intr), 64'b100000);
        finish_frag(46'h00_0000_1000, 200, 1'b0, 1'b0, 1'b0, '0);
        drain();

        // R6: three-fragment gather
        run_frag(46'h100, 400, 1'b1, 1'b0);
        run_frag(46'h200, 500, 1'b1, 1'b0);
        run_frag(46'h300, 600, 1'b0, 1'b1);

        // R3: buffer too full, engine waits; R8 full threshold
        run_frag(46'h400, 1500, 1'b0, 1'b0);
        post_frag(46'h500, 1200, 1'b0, 1'b0);
        for (int k = 0; k < 8; k++) begin
            chk("R3 no request while short of room", 64'(dma_req), 64'd0);
            step();
        end
        do_pop();
        finish_frag(46'h500, 1200, 1'b0, 1'b0, 1'b0, '0);
        run_frag(46'h600, 400, 1'b0, 1'b0);
        drain();

        // R9: post lands in the cycle after completion
        post_frag(46'h700, 100, 1'b0, 1'b0);
        finish_frag(46'h700, 100, 1'b0, 1'b0, 1'b1, mk_desc(1'b0, 1'b1, 250, 46'h800));
        finish_frag(46'h800, 250, 1'b0, 1'b1, 1'b0, '0);
        drain();

        // R11: oversize chain
        run_frag(46'h900, 2000, 1'b1, 1'b0);
        post_frag(46'hA00, 1500, 1'b0, 1'b0);
        step();
        chk("R11 done word error", 64'(done_word), 64'h6000_0000);
        chk("R11 oversize interrupt", 64'(intr), 64'b010000);
        chk("R11 no dma request", 64'(dma_req), 64'd0);
        asm_m = 0;
        run_frag(46'hB00, 500, 1'b0, 1'b0);
        drain();

        // random phase
        for (int f = 0; f < 40; f++) begin
            int nfr;
            nfr = $urandom_range(1, 3);
            for (int g = 0; g < nfr; g++) begin
                int len;
                bit more;
                bit cs;
                logic [45:0] a;
                len  = $urandom_range(1, 700);
                more = (g != nfr - 1);
                cs   = $urandom_range(0, 1);
                a    = {14'($urandom), $urandom};
                while ((BUF - used_m) < asm_m + len && q.size() > 0) do_pop();
                if (q.size() > 0 && $urandom_range(0, 9) < 3) do_pop();
                run_frag(a, len, more, cs);
            end
        end
        drain();

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule